// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Core

This block is a behavioural synchronous static memory with four byte lanes and a depth set by a parameter. The address, the chip selects, the address strobe and the write controls are captured on the rising clock edge. A read returns its word in the same cycle as the edge that captured the address, because no output register sits between the array and the read port. A write can store any subset of byte lanes. A global-write control stores the whole word, whatever the lane controls say.

The core does not step through bursts by itself. A separate burst address generator supplies the next address on a dedicated input. The strobe chooses between that input and the external address on each cycle, so a fresh address can be used on every cycle and bursts are optional. Output enable and sleep act without waiting for a clock. The bidirectional data pins are reduced to a read data bus and a drive-enable flag.

Top module: `fts_sram`

## Requirements
- R1: The address, selects, strobe, write controls and write data are captured on the rising edge of `clk_i`. For a read, `rdata_o` shows the addressed word during the cycle that follows that same edge. There is no additional pipeline stage.
- R2: A cycle is selected only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0 at the edge. Any other combination leaves the memory unchanged.
- R3: With `gwe_ni`=1 and `bwe_ni`=0, each lane i whose `byte_en_ni[i]`=0 is written. Lane i is data bits [8i+7:8i]. Every other lane keeps its old value.
- R4: With `gwe_ni`=0, all four lanes are written, whatever `bwe_ni` and `byte_en_ni` are.
- R5: A selected cycle with `gwe_ni`=0 or `bwe_ni`=0 is a write, and `drive_o` is 0 in the following cycle. A selected cycle with both high is a read and writes nothing.
- R6: A cycle deselected at an edge turns `drive_o` off in the cycle right after that edge.
- R7: `oe_ni`=1 forces `drive_o` to 0 at once, without a clock edge. `drive_o` comes back when `oe_ni` returns to 0.
- R8: `sleep_i`=1 forces `drive_o` to 0 at once. Any access at an edge while `sleep_i` is high is ignored, and stored data is kept. The first edge after release operates normally.
- R9: `addr_strobe_ni`=0 selects `addr_i` as the access address. `addr_strobe_ni`=1 selects `burst_addr_i`.
- R10: A read in the cycle right after a write to the same address returns the new data. Reads to different addresses on consecutive cycles each return their own word.
- R11: After reset, `drive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| burst_addr_i | input | ADDR_W | Address from the burst generator |
| addr_strobe_ni | input | 1 | Low: use addr_i; high: use burst_addr_i |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| gwe_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| byte_en_ni | input | LANES | Per-lane write enables, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| sleep_i | input | 1 | Sleep, asynchronous, active high |
| rdata_o | output | LANES*LANE_W | Flow-through read data |
| drive_o | output | 1 | Read data valid and driven |

## Verification
The main function is exercised with several write patterns: global writes, global writes with conflicting lane controls, a sparse lane mask, and lane enables given without the byte-write enable. Between them they separate lane masking, the global override, and the case where a lane mask wrongly writes. Each wrong chip-enable combination is tried alone with a global write. This exposes a decode that ignores any one of the three selects. Reads on consecutive cycles to different addresses, and a read just after a write, show whether a stray pipeline stage or stale data is present. Reads through the burst address input show that the address source follows the strobe.

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/fts_sram_ctrl.sv
module fts_sram_ctrl
  import fts_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] burst_addr_i,
  input  logic              addr_strobe_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              gwe_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  byte_en_ni,
  input  logic              sleep_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output op_e               op_q_o
);
  logic sel, is_wr;
  op_e  op_d;

  assign sel        = !ce1_ni && ce2_i && !ce3_ni && !sleep_i;
  assign is_wr      = !gwe_ni || !bwe_ni;
  assign acc_addr_o = addr_strobe_ni ? burst_addr_i : addr_i;

  for (genvar i = 0; i < LANES; i++) begin : g_lane_we
    assign lane_we_o[i] = sel && (!gwe_ni || (!bwe_ni && !byte_en_ni[i]));
  end

  always_comb begin
    op_d = OP_IDLE;
    if (sel) op_d = is_wr ? OP_WRITE : OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q_o   <= OP_IDLE;
      addr_q_o <= '0;
    end else begin
      op_q_o <= op_d;
      if (sel) addr_q_o <= acc_addr_o;
    end
  end
endmodule

// File: rtl/fts_sram_array.sv
module fts_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[i]) mem[waddr_i] <= wdata_i[i*LANE_W +: LANE_W];
    end
    // flow-through: no output register
    assign rdata_o[i*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] burst_addr_i,
  input  logic              addr_strobe_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              gwe_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  byte_en_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic [ADDR_W-1:0] acc_addr, addr_q;
  logic [LANES-1:0]  lane_we;
  op_e               op_q;

  fts_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .burst_addr_i, .addr_strobe_ni,
    .ce1_ni, .ce2_i, .ce3_ni, .gwe_ni, .bwe_ni, .byte_en_ni, .sleep_i,
    .acc_addr_o(acc_addr), .lane_we_o(lane_we), .addr_q_o(addr_q), .op_q_o(op_q)
  );

  fts_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .we_i(lane_we), .waddr_i(acc_addr), .wdata_i,
    .raddr_i(addr_q), .rdata_o
  );

  // oe and sleep act without a clock
  assign drive_o = (op_q == OP_READ) && !oe_ni && !sleep_i;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce1_ni,
  input logic             ce2_i,
  input logic             ce3_ni,
  input logic             gwe_ni,
  input logic             bwe_ni,
  input logic             oe_ni,
  input logic             sleep_i,
  input logic             drive_o
);
  logic sel_in;
  assign sel_in = !ce1_ni && ce2_i && !ce3_ni;

  assert_deselect_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_in |=> !drive_o);
  assert_write_no_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gwe_ni || !bwe_ni) |=> !drive_o);
  assert_sleep_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !drive_o);
  assert_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);
  assert_read_drives_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_in && gwe_ni && bwe_ni && !sleep_i) |=> (drive_o || oe_ni || sleep_i));
endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i, .rst_ni, .ce1_ni, .ce2_i, .ce3_ni, .gwe_ni, .bwe_ni,
  .oe_ni, .sleep_i, .drive_o
);

// File: tb/fts_sram_test.sv
module fts_sram_test;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 0, rst_ni = 0;
  logic [AW-1:0] addr = '0, baddr = '0;
  logic          strobe_n = 0, ce1_n = 1, ce2 = 0, ce3_n = 1;
  logic          gwe_n = 1, bwe_n = 1, oe_n = 0, sleep = 0;
  logic [3:0]    ben_n = 4'hF;
  logic [DW-1:0] wdata = '0, rdata;
  logic          drive;
  logic [DW-1:0] model [64];
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  fts_sram uut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .burst_addr_i(baddr),
    .addr_strobe_ni(strobe_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .gwe_ni(gwe_n), .bwe_ni(bwe_n), .byte_en_ni(ben_n), .wdata_i(wdata),
    .oe_ni(oe_n), .sleep_i(sleep), .rdata_o(rdata), .drive_o(drive)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sel(input bit c1n, input bit c2, input bit c3n);
    ce1_n = c1n; ce2 = c2; ce3_n = c3n;
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit g_n, input bit b_n, input logic [3:0] be_n);
    sel(0, 1, 0); strobe_n = 0; addr = a; wdata = d; gwe_n = g_n; bwe_n = b_n; ben_n = be_n;
    tick;
    gwe_n = 1; bwe_n = 1; ben_n = 4'hF;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    sel(0, 1, 0); strobe_n = 0; addr = a; gwe_n = 1; bwe_n = 1;
    tick;
    chk(drive === 1'b1, req, {31'd0, drive}, 32'd1);
    chk(rdata === model[a], req, rdata, model[a]);
  endtask

  task automatic t_reset;
    chk(drive === 1'b0, "R11", {31'd0, drive}, 32'd0);
  endtask

  task automatic t_global;
    wr(6'd1, 32'h1111_2222, 0, 1, 4'hF); model[1] = 32'h1111_2222;
    wr(6'd2, 32'hA5A5_5A5A, 0, 0, 4'b0110); model[2] = 32'hA5A5_5A5A; // R4 override
    chk(drive === 1'b0, "R5", {31'd0, drive}, 32'd0);
    wr(6'd3, 32'hDEAD_BEEF, 0, 1, 4'h0); model[3] = 32'hDEAD_BEEF;
    rd(6'd1, "R4");
    rd(6'd2, "R4");
    rd(6'd3, "R4");
  endtask

  task automatic t_bytes;
    wr(6'd2, 32'h0102_0304, 1, 0, 4'b1010); model[2] = 32'hA502_5A04;
    rd(6'd2, "R3");
    wr(6'd3, 32'hFFFF_FFFF, 1, 0, 4'b0111); model[3] = 32'hFFAD_BEEF;
    rd(6'd3, "R3");
  endtask

  task automatic t_no_bwe;
    wr(6'd1, 32'h0, 1, 1, 4'h0); // lane enables without byte-write: a read
    chk(drive === 1'b1, "R5", {31'd0, drive}, 32'd1);
    rd(6'd1, "R5");
  endtask

  task automatic t_decode;
    for (int k = 0; k < 3; k++) begin
      sel(k == 0, k != 1, k == 2); strobe_n = 0; addr = 6'd1; wdata = 32'hBAD0_BAD0; gwe_n = 0;
      tick;
      gwe_n = 1;
      chk(drive === 1'b0, "R2", {31'd0, drive}, 32'd0);
    end
    rd(6'd1, "R2");
  endtask

  task automatic t_scd;
    rd(6'd3, "R6");
    sel(1, 1, 0);
    tick;
    chk(drive === 1'b0, "R6", {31'd0, drive}, 32'd0);
  endtask

  task automatic t_oe;
    rd(6'd2, "R7");
    oe_n = 1; #0.5;
    chk(drive === 1'b0, "R7", {31'd0, drive}, 32'd0);
    oe_n = 0; #0.5;
    chk(drive === 1'b1, "R7", {31'd0, drive}, 32'd1);
  endtask

  task automatic t_sleep;
    rd(6'd1, "R8");
    sleep = 1; #0.5;
    chk(drive === 1'b0, "R8", {31'd0, drive}, 32'd0);
    sel(0, 1, 0); addr = 6'd1; wdata = 32'h7777_7777; gwe_n = 0;
    tick; tick;
    gwe_n = 1; sleep = 0;
    rd(6'd1, "R8");
  endtask

  task automatic t_burst_port;
    sel(0, 1, 0); strobe_n = 1; addr = 6'd1; baddr = 6'd3; gwe_n = 1; bwe_n = 1;
    tick;
    chk(rdata === model[3], "R9", rdata, model[3]);
    strobe_n = 0;
    rd(6'd1, "R9");
  endtask

  task automatic t_b2b;
    wr(6'd9, 32'h1357_9BDF, 0, 1, 4'hF); model[9] = 32'h1357_9BDF;
    rd(6'd9, "R10");
    rd(6'd2, "R10");
    rd(6'd1, "R10");
    rd(6'd9, "R1");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    t_reset;
    t_global;
    t_bytes;
    t_no_bwe;
    t_decode;
    t_scd;
    t_oe;
    t_sleep;
    t_burst_port;
    t_b2b;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule